// File: doc/BRIEF.md
# Turn-Scheduled Programmable Delay Line

This block holds back a continuous sample stream by a programmable whole number of clock cycles, then spreads each delayed sample over a twelve-word output frame so that a downstream serializer running twelve times faster can place it with a step of one twelfth of a sample period. The coarse delay comes from a dual-port sample RAM. The write counter advances every cycle. The read counter trails it and is realigned to address zero whenever the write counter reaches the delay minus one.

The delay and the fine slot are not static. A small lookup table holds one coarse/fine pair per turn and is loaded through a plain address/data/write-enable port. A turn counter steps through the table on each enabled turn marker, so the delay can follow a clock whose frequency sweeps across a machine cycle. A new pair takes effect only at a turn marker. A table write made in the middle of a turn therefore never disturbs the turn in progress.

Top module: `turn_delay_line`

## Requirements
- R1: While reset is asserted, `dout` and every word of `frame_out` read zero.
- R2: Once a coarse delay D has been loaded and DEPTH (256) cycles have elapsed, `dout` after any clock edge equals the `din` value sampled D edges earlier. This holds down to D = 1.
- R3: The largest coarse delay equals the RAM depth, 256 cycles, and it delays the stream exactly 256 cycles.
- R4: A coarse value of zero read from the table is applied as 1. A coarse value above 256 is applied as 256.
- R5: On a clock edge where `turn_mark` and `enable` are both high, the block loads the table entry indexed by the turn counter and then advances the counter by one. The first such marker after reset loads entry 0.
- R6: A `turn_mark` with `enable` low changes neither the active delay nor the turn counter.
- R7: Table writes do not change the active delay or fine slot until the next enabled turn marker.
- R8: The turn counter stops at entry 63. Further enabled markers reload entry 63 and pick up its current contents.
- R9: `frame_out` is registered one cycle behind `dout`. Slot s occupies bits [16*s+15:16*s]. Slots s >= F hold the current `dout` sample, and slots s < F hold the sample before it, where F is the active fine value.
- R10: A fine value above 11 read from the table is applied as 11.
- R11: With fine value 0, all twelve slots carry the current sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Input sample, taken every cycle |
| turn_mark | input | 1 | One-cycle marker at the start of a turn |
| enable | input | 1 | Qualifies `turn_mark` |
| lut_we | input | 1 | Lookup table write strobe |
| lut_addr | input | 6 | Lookup table entry index |
| lut_coarse | input | 9 | Coarse delay to store, in cycles |
| lut_fine | input | 4 | Fine slot to store, 0 to 11 |
| dout | output | 16 | Coarse-delayed sample |
| frame_out | output | 192 | Twelve output words, slot 0 in the low bits |

## Verification
The properties take for granted that reset is held for at least one edge before anything is judged. They also assume the table entry reached by a marker was written beforehand, because unwritten entries hold arbitrary values that the clamp then absorbs. The stimulus writes every table entry before the marker that reaches it. It keeps the input as a running count, so that any delay error shows up as a numeric offset. It waits a full RAM depth after each delay change before comparing, which lets the read counter realign.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    // Fine field width and frame slot count are fixed by the serializer ratio.
    localparam int FINE_W      = 4;
    localparam int FRAME_SLOTS = 12;

    typedef logic [FINE_W-1:0] fine_t;

    // Limit a stored fine value to the last frame slot.
    function automatic fine_t clamp_fine(input fine_t raw);
        if (raw > fine_t'(FRAME_SLOTS - 1)) begin
            return fine_t'(FRAME_SLOTS - 1);
        end
        return raw;
    endfunction
endpackage

// File: rtl/tdl_delay_ram.sv
module tdl_delay_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int DLY_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DLY_W-1:0]  delay,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [AW-1:0]     wr;
        logic [AW-1:0]     rd;
        logic [DATA_W-1:0] rdata;
    } ram_state_t;

    ram_state_t s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DLY_W-1:0]  delay_m1;
    logic              wr_hits;

    always_comb begin
        delay_m1 = delay - DLY_W'(1);
        wr_hits  = (DLY_W'(s_q.wr) == delay_m1);
        s_d       = s_q;
        s_d.wr    = s_q.wr + AW'(1);
        // Read counter realigns to zero so that it trails the writer by delay.
        s_d.rd    = wr_hits ? '0 : s_q.rd + AW'(1);
        // Reading before the same-edge write gives old data, so delay=DEPTH works.
        s_d.rdata = mem[s_q.rd];
    end

    always_ff @(posedge clk) begin
        mem[s_q.wr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.rdata;
endmodule

// File: rtl/tdl_turn_lut.sv
module tdl_turn_lut
    import tdl_pkg::*;
#(
    parameter int LUT_DEPTH = 64,
    parameter int DEPTH     = 256,
    localparam int LAW      = $clog2(LUT_DEPTH),
    localparam int DLY_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_mark,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [LAW-1:0]   wr_addr,
    input  logic [DLY_W-1:0] wr_coarse,
    input  fine_t            wr_fine,
    output logic [DLY_W-1:0] act_delay,
    output fine_t            act_fine,
    output logic [LAW-1:0]   turn_idx
);
    typedef struct packed {
        logic [LAW-1:0]   turn;
        logic [DLY_W-1:0] delay;
        fine_t            fine;
    } lut_state_t;

    lut_state_t s_d, s_q;
    logic [DLY_W-1:0] tab_coarse [LUT_DEPTH];
    fine_t            tab_fine   [LUT_DEPTH];
    logic [DLY_W-1:0] raw_coarse;
    fine_t            raw_fine;
    logic [DLY_W-1:0] lim_coarse;
    logic             load;

    always_comb begin
        raw_coarse = tab_coarse[s_q.turn];
        raw_fine   = tab_fine[s_q.turn];
        if (raw_coarse == '0) begin
            lim_coarse = DLY_W'(1);
        end else if (raw_coarse > DLY_W'(DEPTH)) begin
            lim_coarse = DLY_W'(DEPTH);
        end else begin
            lim_coarse = raw_coarse;
        end

        load = turn_mark && enable;
        s_d  = s_q;
        if (load) begin
            s_d.delay = lim_coarse;
            s_d.fine  = clamp_fine(raw_fine);
            if (s_q.turn != LAW'(LUT_DEPTH - 1)) begin
                s_d.turn = s_q.turn + LAW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tab_coarse[wr_addr] <= wr_coarse;
            tab_fine[wr_addr]   <= wr_fine;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.turn  <= '0;
            s_q.delay <= DLY_W'(1);
            s_q.fine  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_delay = s_q.delay;
    assign act_fine  = s_q.fine;
    assign turn_idx  = s_q.turn;
endmodule

// File: rtl/tdl_fine_frame.sv
module tdl_fine_frame
    import tdl_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int FW    = FRAME_SLOTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample,
    input  fine_t             fine,
    output logic [FW-1:0]     frame_out
);
    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic [FW-1:0]     frame;
    } frame_state_t;

    frame_state_t s_d, s_q;
    logic [FW-1:0] frame_next;

    // One selector per slot: slots before the fine point keep the older sample.
    for (genvar s = 0; s < FRAME_SLOTS; s++) begin : g_slot
        assign frame_next[s*DATA_W +: DATA_W] =
            (fine_t'(s) < fine) ? s_q.prev : sample;
    end

    always_comb begin
        s_d       = s_q;
        s_d.prev  = sample;
        s_d.frame = frame_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_out = s_q.frame;
endmodule

// File: rtl/turn_delay_line.sv
module turn_delay_line
    import tdl_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 256,
    parameter int LUT_DEPTH = 64,
    localparam int DLY_W    = $clog2(DEPTH + 1),
    localparam int LAW      = $clog2(LUT_DEPTH),
    localparam int FW       = FRAME_SLOTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              turn_mark,
    input  logic              enable,
    input  logic              lut_we,
    input  logic [LAW-1:0]    lut_addr,
    input  logic [DLY_W-1:0]  lut_coarse,
    input  logic [FINE_W-1:0] lut_fine,
    output logic [DATA_W-1:0] dout,
    output logic [FW-1:0]     frame_out
);
    logic [DLY_W-1:0] act_delay;
    fine_t            act_fine;
    logic [LAW-1:0]   turn_idx;

    tdl_turn_lut #(.LUT_DEPTH(LUT_DEPTH), .DEPTH(DEPTH)) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .turn_mark (turn_mark),
        .enable    (enable),
        .wr_en     (lut_we),
        .wr_addr   (lut_addr),
        .wr_coarse (lut_coarse),
        .wr_fine   (lut_fine),
        .act_delay (act_delay),
        .act_fine  (act_fine),
        .turn_idx  (turn_idx)
    );

    tdl_delay_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .delay (act_delay),
        .dout  (dout)
    );

    tdl_fine_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (dout),
        .fine      (act_fine),
        .frame_out (frame_out)
    );
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker
    import tdl_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 256,
    parameter int LUT_DEPTH = 64,
    localparam int DLY_W    = $clog2(DEPTH + 1),
    localparam int LAW      = $clog2(LUT_DEPTH),
    localparam int FW       = FRAME_SLOTS * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              turn_mark,
    input logic              enable,
    input logic [DATA_W-1:0] dout,
    input logic [FW-1:0]     frame_out,
    input logic [DLY_W-1:0]  act_delay,
    input fine_t             act_fine,
    input logic [LAW-1:0]    turn_idx
);
    logic [DATA_W-1:0]      dout_prev;
    logic [FRAME_SLOTS-1:0] slot_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) dout_prev <= '0;
        else        dout_prev <= dout;
    end

    for (genvar s = 0; s < FRAME_SLOTS; s++) begin : g_cmp
        assign slot_cur[s] = (frame_out[s*DATA_W +: DATA_W] == dout_prev);
    end

    assert_delay_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_delay >= DLY_W'(1)) && (act_delay <= DLY_W'(DEPTH)));

    assert_fine_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        act_fine <= fine_t'(FRAME_SLOTS - 1));

    assert_turn_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_mark && enable && turn_idx != LAW'(LUT_DEPTH - 1))
        |=> turn_idx == $past(turn_idx) + LAW'(1));

    assert_turn_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(turn_mark && enable) |=> $stable(turn_idx));

    assert_midturn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(turn_mark && enable) |=> ($stable(act_delay) && $stable(act_fine)));

    assert_turn_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_idx == LAW'(LUT_DEPTH - 1)) |=> turn_idx == LAW'(LUT_DEPTH - 1));

    assert_top_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cur[FRAME_SLOTS-1]);

    assert_fine_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fine == '0) |=> (&slot_cur));
endmodule

bind turn_delay_line tdl_checker #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .LUT_DEPTH (LUT_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .turn_mark (turn_mark),
    .enable    (enable),
    .dout      (dout),
    .frame_out (frame_out),
    .act_delay (act_delay),
    .act_fine  (act_fine),
    .turn_idx  (turn_idx)
);

// File: tb/sim_turn_delay_line.sv
`timescale 1ns/100ps
module sim_turn_delay_line;
    localparam int DW = 16;
    localparam int SL = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic          turn_mark, enable, lut_we;
    logic [5:0]    lut_addr;
    logic [8:0]    lut_coarse;
    logic [3:0]    lut_fine;
    logic [DW-1:0] dout;
    logic [SL*DW-1:0] frame_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    turn_delay_line u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .turn_mark  (turn_mark),
        .enable     (enable),
        .lut_we     (lut_we),
        .lut_addr   (lut_addr),
        .lut_coarse (lut_coarse),
        .lut_fine   (lut_fine),
        .dout       (dout),
        .frame_out  (frame_out)
    );

    // Running count as input stream: a delay error shows as an offset.
    initial begin
        din = '0;
        forever @(negedge clk) din <= din + 1'b1;
    end

    task automatic lut_write(input int addr, input int coarse, input int fine);
        @(negedge clk);
        lut_we = 1'b1; lut_addr = 6'(addr); lut_coarse = 9'(coarse); lut_fine = 4'(fine);
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    task automatic pulse_mark(input bit en);
        @(negedge clk);
        turn_mark = 1'b1; enable = en;
        @(negedge clk);
        turn_mark = 1'b0; enable = 1'b0;
    endtask

    task automatic check_delay(input int d, input int f, input string tag);
        logic [DW-1:0]    e_now, e_cur, e_prev;
        logic [SL*DW-1:0] e_frame;
        repeat (300) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            e_now  = din - DW'(1 + d);
            e_cur  = din - DW'(2 + d);
            e_prev = din - DW'(3 + d);
            for (int s = 0; s < SL; s++) e_frame[s*DW +: DW] = (s < f) ? e_prev : e_cur;
            n_chk++;
            if (dout !== e_now) begin
                n_err++;
                $display("FAIL %s dout: actual=%h expected=%h (delay %0d)", tag, dout, e_now, d);
            end
            n_chk++;
            if (frame_out !== e_frame) begin
                n_err++;
                $display("FAIL %s frame: actual=%h expected=%h (fine %0d)", tag, frame_out, e_frame, f);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0; turn_mark = 0; enable = 0; lut_we = 0;
        lut_addr = '0; lut_coarse = '0; lut_fine = '0;
        repeat (5) @(negedge clk);
        #1;
        n_chk++;
        if (dout !== '0) begin
            n_err++; $display("FAIL R1 dout: actual=%h expected=0", dout);
        end
        n_chk++;
        if (frame_out !== '0) begin
            n_err++; $display("FAIL R1 frame: actual=%h expected=0", frame_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill_table();
        lut_write(0, 5, 0);
        lut_write(1, 20, 2);
        lut_write(2, 0, 3);
        lut_write(3, 300, 15);
        lut_write(4, 1, 6);
        for (int a = 5; a < 62; a++) lut_write(a, 3, 1);
        lut_write(62, 9, 4);
        lut_write(63, 7, 2);
    endtask

    task automatic test_first_turn();
        pulse_mark(1'b1);
        check_delay(5, 0, "R2 R5 R11");
    endtask

    task automatic test_disabled_marker();
        pulse_mark(1'b0);
        check_delay(5, 0, "R6");
    endtask

    task automatic test_midturn_write();
        lut_write(1, 256, 11);
        check_delay(5, 0, "R7");
        pulse_mark(1'b1);
        check_delay(256, 11, "R3 R6 R7 R9");
    endtask

    task automatic test_clamps();
        pulse_mark(1'b1);
        check_delay(1, 3, "R4 R9");
        pulse_mark(1'b1);
        check_delay(256, 11, "R4 R10");
        pulse_mark(1'b1);
        check_delay(1, 6, "R2 R9");
    endtask

    task automatic test_saturation();
        for (int t = 5; t < 62; t++) pulse_mark(1'b1);
        pulse_mark(1'b1);
        check_delay(9, 4, "R5 R8");
        pulse_mark(1'b1);
        check_delay(7, 2, "R8");
        lut_write(63, 11, 5);
        pulse_mark(1'b1);
        check_delay(11, 5, "R8");
    endtask

    initial begin
        test_reset();
        fill_table();
        test_first_turn();
        test_disabled_marker();
        test_midturn_write();
        test_clamps();
        test_saturation();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL timeout R1..: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule